// File: doc/BRIEF.md
# Saturating Return-Address Stack

This block is a small last-in-first-out store of 12-bit words, nine entries deep. A microprogram sequencer pushes subroutine return addresses and loop start addresses into it. The pointer always names the most recently written word, so the top entry is on the output at all times and can be used again and again without popping it. A loop can therefore branch back to its start on every pass and leave the entry in place.

The block has three commands: push, pop and clear. When more than one is asserted in a cycle, clear wins over push and push wins over pop. Overflow and underflow both have defined results, so a misbehaving microprogram cannot corrupt the pointer. A push into a full stack replaces the top word and leaves the depth at nine. A pop from an empty stack leaves the depth at zero.

An active-low flag reports a full stack. While the stack is empty the top output reads zero. Address selection and instruction decode are left to the surrounding sequencer.

Top module: `lifo_return_stack`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) empties the stack. From the next cycle top_o reads 0 and full_n_o reads 1.
- R2: A push (push_i=1, clear_i=0) stores wr_data_i as the new top entry, and top_o shows that word in the cycle after the edge.
- R3: In a cycle with no command asserted, top_o and full_n_o keep their values, so the top entry can be read any number of times without a pop.
- R4: A pop (pop_i=1, push_i=0, clear_i=0) on a non-empty stack removes the top entry. In the next cycle top_o shows the entry that was pushed before it.
- R5: While the stack holds no entries, top_o reads 0.
- R6: full_n_o is 0 exactly when nine entries are held. It first goes low in the cycle after the ninth push.
- R7: A push while nine entries are held replaces the top entry with wr_data_i, and the depth stays at nine (full_n_o stays 0).
- R8: A pop while the stack is empty leaves the depth at zero. The next push then becomes the only entry.
- R9: A clear (clear_i=1) empties the stack from any depth, and the write data of that cycle is not stored.
- R10: Command priority is clear over push over pop. When push and pop are asserted together, only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Empty the stack |
| push_i | input | 1 | Push wr_data_i |
| pop_i | input | 1 | Drop the top entry |
| wr_data_i | input | 12 | Word to push |
| top_o | output | 12 | Current top entry, 0 when empty |
| full_n_o | output | 1 | Low when nine entries are held |

## Verification
The stack is exercised with four kinds of input pattern. A short mixed sequence of push, pop, idle and combined commands separates correct command priority from a design that performs both push and pop, or that lets clear lose. A fill to nine entries, checked after every push, catches a full flag that asserts one entry early or one entry late. Pushes beyond nine separate an overwrite of the top entry from one that moves the pointer or writes a neighbouring word. Pops past empty, each followed by a push, show whether the pointer wrapped instead of holding at zero.

// File: rtl/ret_stack_pkg.sv
// Package: shared command encoding for the return-address stack.
// Assumes: exactly one command is acted on per cycle after priority resolution.
package ret_stack_pkg;
    typedef enum logic [1:0] {
        STK_IDLE  = 2'd0,
        STK_PUSH  = 2'd1,
        STK_POP   = 2'd2,
        STK_CLEAR = 2'd3
    } stk_cmd_e;
endpackage

// File: rtl/ret_stack_arb.sv
// Module: ret_stack_arb
// Reduces the three raw command inputs to one command, with clear ranked
// above push and push ranked above pop (R10).
// Assumes: inputs are synchronous to the stack clock.
module ret_stack_arb
    import ret_stack_pkg::*;
(
    input  logic     clear_i,
    input  logic     push_i,
    input  logic     pop_i,
    output stk_cmd_e cmd_o
);
    // Priority encode the commands
    always_comb begin
        if (clear_i)     cmd_o = STK_CLEAR;
        else if (push_i) cmd_o = STK_PUSH;
        else if (pop_i)  cmd_o = STK_POP;
        else             cmd_o = STK_IDLE;
    end
endmodule

// File: rtl/ret_stack_ptr.sv
// Module: ret_stack_ptr
// Holds the depth counter (0..DEPTH) and decides the write location.
// A push at full depth rewrites the last location without counting; a pop
// at zero depth is dropped.
// Assumes: synchronous active-low reset; one command per cycle.
module ret_stack_ptr
    import ret_stack_pkg::*;
#(
    parameter int DEPTH  = 9,
    parameter int PTR_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_cmd_e          cmd_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              full_o
);
    localparam logic [PTR_W-1:0]  FULL_LVL = PTR_W'(DEPTH);
    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    assign full_o = (ptr_q == FULL_LVL);
    assign ptr_o  = ptr_q;

    // Next depth and write request for the resolved command
    always_comb begin
        ptr_d     = ptr_q;
        wr_en_o   = 1'b0;
        wr_addr_o = ADDR_W'(ptr_q);
        unique case (cmd_i)
            STK_CLEAR: ptr_d = '0;
            STK_PUSH: begin
                wr_en_o = rst_n;
                if (full_o) begin
                    wr_addr_o = LAST_IDX;
                end else begin
                    ptr_d = ptr_q + PTR_W'(1);
                end
            end
            STK_POP: begin
                if (ptr_q != '0) ptr_d = ptr_q - PTR_W'(1);
            end
            default: ptr_d = ptr_q;
        endcase
    end

    // Depth register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end
endmodule

// File: rtl/ret_stack_file.sv
// Module: ret_stack_file
// Word storage: one write port, one combinational read port.
// Assumes: storage is not reset; reads of unwritten words are masked upstream.
module ret_stack_file #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 9,
    parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Capture data into this word when addressed
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_addr_i == ADDR_W'(g))) word_q[g] <= wr_data_i;
        end
    end

    // Read mux; out-of-range addresses read zero
    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr_i == ADDR_W'(i)) rd_data_o = word_q[i];
        end
    end
endmodule

// File: rtl/lifo_return_stack.sv
// Module: lifo_return_stack (top)
// Nine-deep return-address stack with an always-visible top entry,
// overwrite-on-overflow and hold-on-underflow.
// Assumes: synchronous active-low reset; the caller resolves no conflicts
// itself, the priority is applied here.
module lifo_return_stack
    import ret_stack_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] top_o,
    output logic              full_n_o
);
    localparam int PTR_W  = $clog2(DEPTH + 1);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    stk_cmd_e          cmd;
    logic [PTR_W-1:0]  ptr_q;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic              full;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    ret_stack_arb u_arb (
        .clear_i (clear_i),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .cmd_o   (cmd)
    );

    ret_stack_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd),
        .ptr_o     (ptr_q),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .full_o    (full)
    );

    ret_stack_file #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_file (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    // Top entry sits one below the depth count
    always_comb begin
        rd_addr = ADDR_W'(ptr_q - PTR_W'(1));
        top_o   = (ptr_q == '0) ? '0 : rd_data;
    end

    assign full_n_o = ~full;
endmodule

// File: rtl/ret_stack_chk.sv
// Module: ret_stack_chk
// Property checker bound to lifo_return_stack; observes ports and the depth count.
module ret_stack_chk #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 9,
    parameter int PTR_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              push_i,
    input logic              pop_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] top_o,
    input logic              full_n_o,
    input logic [PTR_W-1:0]  ptr_q
);
    AST_PUSH_SHOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !clear_i) |=> (top_o == $past(wr_data_i))); // R2
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i && !clear_i) |=> ($stable(top_o) && $stable(full_n_o))); // R3
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == '0) |-> (top_o == '0)); // R5
    AST_FULL_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_n_o) |-> $past(push_i && !clear_i)); // R6
    AST_DEPTH_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q <= PTR_W'(DEPTH))); // R6
    AST_OVERFLOW_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_n_o && push_i && !clear_i) |=> !full_n_o); // R7
    AST_UNDERFLOW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ptr_q == '0) && pop_i && !push_i && !clear_i) |=> (ptr_q == '0)); // R8
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> ((top_o == '0) && full_n_o)); // R9
endmodule

bind lifo_return_stack ret_stack_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_i),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_data_i (wr_data_i),
    .top_o     (top_o),
    .full_n_o  (full_n_o),
    .ptr_q     (ptr_q)
);

// File: tb/lifo_return_stack_tb_top.sv
// Bench: table-driven sequence followed by directed fill, overflow,
// underflow and reset tests against a reference model.
module lifo_return_stack_tb_top;
    localparam int DW = 12;
    localparam int DP = 9;

    typedef struct packed {
        logic          clr;
        logic          psh;
        logic          pp;
        logic [DW-1:0] dat;
        logic [DW-1:0] exp_top;
        logic          exp_full_n;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 12'h101, 12'h101, 1'b1}, // R2 first push
        '{1'b0, 1'b1, 1'b0, 12'h202, 12'h202, 1'b1}, // R2 second push
        '{1'b0, 1'b0, 1'b0, 12'h3AB, 12'h202, 1'b1}, // R3 idle keeps top
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h101, 1'b1}, // R4 pop reveals older
        '{1'b0, 1'b1, 1'b1, 12'h303, 12'h303, 1'b1}, // R10 push beats pop
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h101, 1'b1}, // R4 pop
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h000, 1'b1}, // R5 now empty
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h000, 1'b1}, // R8 pop on empty
        '{1'b0, 1'b1, 1'b0, 12'h0AA, 12'h0AA, 1'b1}, // R8 push lands as only entry
        '{1'b1, 1'b1, 1'b0, 12'h555, 12'h000, 1'b1}, // R9 clear beats push
        '{1'b0, 1'b1, 1'b0, 12'hFFF, 12'hFFF, 1'b1}, // R2 push after clear
        '{1'b0, 1'b0, 1'b1, 12'h000, 12'h000, 1'b1}  // R9 clear left one-deep stack empty
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 1'b0;
    logic          push_i = 1'b0;
    logic          pop_i = 1'b0;
    logic [DW-1:0] wr_data_i = '0;
    logic [DW-1:0] top_o;
    logic          full_n_o;

    int n_chk  = 0;
    int n_fail = 0;
    int mdep   = 0;
    logic [DW-1:0] mst [DP];

    always #4 clk = ~clk;

    lifo_return_stack #(.DATA_W(DW), .DEPTH(DP)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_i),
        .push_i    (push_i),
        .pop_i     (pop_i),
        .wr_data_i (wr_data_i),
        .top_o     (top_o),
        .full_n_o  (full_n_o)
    );

    task automatic check(input string req, input logic [DW-1:0] et, input logic ef);
        n_chk++;
        if (top_o !== et || full_n_o !== ef) begin
            n_fail++;
            $display("FAIL %s: top=%h full_n=%b, expected top=%h full_n=%b",
                     req, top_o, full_n_o, et, ef);
        end
    endtask

    // Drive one command at the falling edge, sample just after the next rising edge
    task automatic apply(input logic c, input logic p, input logic o, input logic [DW-1:0] d);
        @(negedge clk);
        clear_i = c; push_i = p; pop_i = o; wr_data_i = d;
        @(posedge clk);
        #1;
        clear_i = 1'b0; push_i = 1'b0; pop_i = 1'b0;
        if (c) mdep = 0;
        else if (p) begin
            if (mdep < DP) begin mst[mdep] = d; mdep++; end
            else mst[DP-1] = d;
        end else if (o && mdep > 0) mdep--;
    endtask

    function automatic logic [DW-1:0] m_top();
        return (mdep == 0) ? '0 : mst[mdep-1];
    endfunction

    function automatic logic m_full_n();
        return (mdep == DP) ? 1'b0 : 1'b1;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset state", '0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].clr, VECS[i].psh, VECS[i].pp, VECS[i].dat);
            check($sformatf("table vector %0d", i), VECS[i].exp_top, VECS[i].exp_full_n);
        end

        apply(1'b1, 1'b0, 1'b0, '0);
        check("R9 clear", m_top(), m_full_n());

        for (int i = 0; i < DP; i++) begin
            apply(1'b0, 1'b1, 1'b0, DW'(12'h100 + i * 17));
            check((i == DP - 1) ? "R6 full after ninth push" : "R2 R6 fill", m_top(), m_full_n());
        end

        apply(1'b0, 1'b1, 1'b0, 12'hABC);
        check("R7 overflow overwrites top", 12'hABC, 1'b0);
        apply(1'b0, 1'b1, 1'b1, 12'h777);
        check("R7 R10 overflow push with pop", 12'h777, 1'b0);
        apply(1'b0, 1'b0, 1'b0, '0);
        check("R3 idle at full", 12'h777, 1'b0);

        for (int i = 0; i < DP; i++) begin
            apply(1'b0, 1'b0, 1'b1, '0);
            check((i == DP - 1) ? "R5 drained" : "R4 drain", m_top(), m_full_n());
        end
        check("R4 R7 drained to empty", '0, 1'b1);

        apply(1'b0, 1'b0, 1'b1, '0);
        check("R8 underflow", m_top(), m_full_n());
        apply(1'b0, 1'b1, 1'b0, 12'h5A5);
        check("R8 single entry after underflow", 12'h5A5, 1'b1);
        apply(1'b0, 1'b0, 1'b1, '0);
        check("R8 empty again", '0, 1'b1);

        apply(1'b0, 1'b1, 1'b0, 12'h111);
        apply(1'b0, 1'b1, 1'b0, 12'h222);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        mdep = 0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset mid-run", '0, 1'b1);
        apply(1'b0, 1'b1, 1'b0, 12'h9C3);
        check("R1 R2 push after reset", 12'h9C3, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run still active, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule